// File: doc/BRIEF.md
# Hint Effectiveness Tracking Unit

This block sits in the processor that consumes hints from a faulty helper processor and decides, class by class, whether each kind of hint still earns its keep. Every hint type has a saturating up/down score. The memory-side units pulse `useful_i` when a hinted action paid off (for example a hit on a prefetched line) and `wasted_i` when it was wasted effort. A free-running window timer divides time into fixed evaluation windows.

A three-state controller runs the windows. In ST_COLLECT the scores move with the event pulses. When the window timer reaches its last count, the controller takes the T_WINDOW_END transition into ST_VERDICT. In that single cycle each type's enable takes the top bit of its score, and every score is reloaded to exactly half scale, so at the next verdict the top bit alone shows whether that type was at least as often useful as wasted. The unconditional T_PUBLISH transition then leads to ST_ANNOUNCE. For that one cycle the block sends the mask of disabled types to the producer, tagged with the producer identifier. It also pulses a resynchronisation request when more than half of the types are now off. The unconditional T_RESUME transition returns the controller to ST_COLLECT.

Top module: `hint_eval_unit`

## Requirements
- R1: While reset is asserted and right after it, every bit of `type_en_o` is 1, and `report_valid_o` and `resync_o` are 0.
- R2: A `useful_i[i]` pulse raises score i by one and a `wasted_i[i]` pulse lowers it by one. When both pulses arrive for the same type in the same cycle, the score does not change.
- R3: Scores saturate at 0 and at 2^CNT_W-1 and never wrap. Further pulses in the saturated direction have no effect.
- R4: Scores start at 2^(CNT_W-1) after reset and are reloaded to that value in every ST_VERDICT cycle. Event pulses sampled on the edge that ends ST_VERDICT are dropped.
- R5: Rising edges are counted from 1 after reset release. ST_VERDICT is the cycle after edge k·WINDOW, and ST_ANNOUNCE is the cycle after edge k·WINDOW+1. On the edge that ends ST_VERDICT, `type_en_o[i]` takes the top bit of score i, where 1 means enabled.
- R6: `type_en_o` changes only on the edge that ends ST_VERDICT and holds its value at all other times.
- R7: In ST_ANNOUNCE, if any type is disabled, `report_valid_o` is 1 for exactly one cycle. In that cycle `report_mask_o[i]` is 1 exactly when the type with type code i (0 to 2) is disabled, and `report_id_o` equals the `producer_id_i` value sampled during ST_VERDICT. Outside that cycle the valid, mask and identifier outputs are 0.
- R8: `resync_o` is a one-cycle pulse in ST_ANNOUNCE, raised only when the number of disabled types is greater than NUM_TYPES/2. It always coincides with `report_valid_o`.
- R9: A type with equal numbers of useful and wasted pulses in a window ends at exactly half scale and stays enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| useful_i | input | NUM_TYPES | Per-type pulse: a hint of that type was useful |
| wasted_i | input | NUM_TYPES | Per-type pulse: a hint of that type was wasted |
| producer_id_i | input | ID_W | Identifier of the faulty producer processor |
| type_en_o | output | NUM_TYPES | Per-type hint generation enable (1 = on) |
| report_valid_o | output | 1 | Disable report strobe |
| report_mask_o | output | NUM_TYPES | Disabled-type mask, bit i = type code i |
| report_id_o | output | ID_W | Producer identifier tagged on the report |
| resync_o | output | 1 | Request to resynchronise the producer |

## Verification
The bench builds the block with NUM_TYPES=3, CNT_W=4 (half scale 8, top 15), WINDOW=40 and ID_W=6. The narrow score lets about ten pulses drive a counter into either rail within one window, and the sequence is chosen so that a wrapping counter would reach the opposite verdict. The short window places many verdicts within a few hundred cycles. Each window is used for one scenario: a single disable, a majority disable with resync, all types off, a tie, cancelling pulses, a pulse that falls in the verdict cycle, and recovery after a deep disable.

// File: rtl/hint_eval_pkg.sv
package hint_eval_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT  = 2'd0,
        ST_VERDICT  = 2'd1,
        ST_ANNOUNCE = 2'd2
    } eval_state_t;

endpackage

// File: rtl/hint_window_timer.sv
module hint_window_timer #(
    parameter int WINDOW = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic win_end_o
);
    localparam int PW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [PW-1:0] LAST = PW'(WINDOW - 1);

    logic [PW-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (tick_q == LAST) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign win_end_o = (tick_q == LAST);

    // R5: the timer restarts right after the last count of a window
    a_r5_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == LAST) |=> (tick_q == '0));

    // R5: a window end is never two cycles in a row
    a_r5_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        win_end_o |=> !win_end_o);

endmodule

// File: rtl/hint_score_counter.sv
module hint_score_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             reload_i,
    output logic             msb_o
);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] TOP  = '1;

    logic [CNT_W-1:0] score_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score_q <= HALF;
        end else if (reload_i) begin
            score_q <= HALF;
        end else if (up_i && !dn_i && score_q != TOP) begin
            score_q <= score_q + 1'b1;
        end else if (dn_i && !up_i && score_q != '0) begin
            score_q <= score_q - 1'b1;
        end
    end

    assign msb_o = score_q[CNT_W-1];

    // R3: no wrap past the top rail
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && up_i && !dn_i && score_q == TOP) |=> (score_q == TOP));

    // R3: no wrap past zero
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && dn_i && !up_i && score_q == '0) |=> (score_q == '0));

    // R2: simultaneous pulses cancel
    a_r2_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && up_i && dn_i) |=> $stable(score_q));

    // R4: reload lands on half scale
    a_r4_reload_half: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (score_q == HALF));

endmodule

// File: rtl/hint_eval_ctrl.sv
module hint_eval_ctrl
    import hint_eval_pkg::*;
#(
    parameter int NUM_TYPES = 3,
    parameter int ID_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_end_i,
    input  logic [NUM_TYPES-1:0] score_msb_i,
    input  logic [ID_W-1:0]      producer_id_i,
    output logic                 reload_o,
    output logic [NUM_TYPES-1:0] type_en_o,
    output logic                 report_valid_o,
    output logic [NUM_TYPES-1:0] report_mask_o,
    output logic [ID_W-1:0]      report_id_o,
    output logic                 resync_o
);
    localparam int MAJORITY = NUM_TYPES / 2;

    eval_state_t          state_q, state_d;
    logic [NUM_TYPES-1:0] en_q;
    logic [ID_W-1:0]      id_q;
    logic [NUM_TYPES-1:0] off_mask;
    logic                 any_off;
    logic                 too_many_off;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT:  if (win_end_i) state_d = ST_VERDICT;   // T_WINDOW_END
            ST_VERDICT:  state_d = ST_ANNOUNCE;                 // T_PUBLISH
            ST_ANNOUNCE: state_d = ST_COLLECT;                  // T_RESUME
            default:     state_d = ST_COLLECT;
        endcase
    end

    // verdict registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '1;
            id_q <= '0;
        end else if (state_q == ST_VERDICT) begin
            en_q <= score_msb_i;
            id_q <= producer_id_i;
        end
    end

    assign off_mask     = ~en_q;
    assign any_off      = |off_mask;
    assign too_many_off = ($countones(off_mask) > MAJORITY);

    // outputs
    always_comb begin
        reload_o       = 1'b0;
        report_valid_o = 1'b0;
        report_mask_o  = '0;
        report_id_o    = '0;
        resync_o       = 1'b0;
        unique case (state_q)
            ST_COLLECT: ;
            ST_VERDICT: reload_o = 1'b1;
            ST_ANNOUNCE: begin
                if (any_off) begin
                    report_valid_o = 1'b1;
                    report_mask_o  = off_mask;
                    report_id_o    = id_q;
                end
                resync_o = too_many_off;
            end
            default: ;
        endcase
    end

    assign type_en_o = en_q;

    // R6: enables move only on the edge leaving the verdict state
    a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_VERDICT) |=> $stable(type_en_o));

    // R8: resync is a single-cycle pulse
    a_r8_resync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |=> !resync_o);

    // R8: resync always travels with a report
    a_r8_resync_with_report: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |-> report_valid_o);

    // R7: report strobe lasts one cycle
    a_r7_report_single: assert property (@(posedge clk) disable iff (!rst_n)
        report_valid_o |=> !report_valid_o);

    // R4: reload only follows a window end
    a_r4_reload_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reload_o) |-> $past(win_end_i));

endmodule

// File: rtl/hint_eval_unit.sv
module hint_eval_unit #(
    parameter int NUM_TYPES = 3,
    parameter int CNT_W     = 8,
    parameter int WINDOW    = 2000,
    parameter int ID_W      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TYPES-1:0] useful_i,
    input  logic [NUM_TYPES-1:0] wasted_i,
    input  logic [ID_W-1:0]      producer_id_i,
    output logic [NUM_TYPES-1:0] type_en_o,
    output logic                 report_valid_o,
    output logic [NUM_TYPES-1:0] report_mask_o,
    output logic [ID_W-1:0]      report_id_o,
    output logic                 resync_o
);
    logic                 win_end;
    logic                 reload;
    logic [NUM_TYPES-1:0] score_msb;

    hint_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_end_o (win_end)
    );

    for (genvar g = 0; g < NUM_TYPES; g++) begin : g_score
        hint_score_counter #(.CNT_W(CNT_W)) u_score (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_i     (useful_i[g]),
            .dn_i     (wasted_i[g]),
            .reload_i (reload),
            .msb_o    (score_msb[g])
        );
    end

    hint_eval_ctrl #(.NUM_TYPES(NUM_TYPES), .ID_W(ID_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .win_end_i      (win_end),
        .score_msb_i    (score_msb),
        .producer_id_i  (producer_id_i),
        .reload_o       (reload),
        .type_en_o      (type_en_o),
        .report_valid_o (report_valid_o),
        .report_mask_o  (report_mask_o),
        .report_id_o    (report_id_o),
        .resync_o       (resync_o)
    );

endmodule

// File: tb/tb_hint_eval_unit.sv
module tb_hint_eval_unit;
    localparam int NT = 3;
    localparam int CW = 4;
    localparam int W  = 40;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] useful = '0;
    logic [NT-1:0] wasted = '0;
    logic [IW-1:0] pid = 6'h2A;
    logic [NT-1:0] en;
    logic          rv;
    logic [NT-1:0] rmask;
    logic [IW-1:0] rid;
    logic          resync;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    hint_eval_unit #(.NUM_TYPES(NT), .CNT_W(CW), .WINDOW(W), .ID_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .useful_i(useful), .wasted_i(wasted),
        .producer_id_i(pid), .type_en_o(en), .report_valid_o(rv),
        .report_mask_o(rmask), .report_id_o(rid), .resync_o(resync)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic at_phase(input int ph);
        do @(negedge clk); while ((ecnt % W) != ph);
    endtask

    task automatic drive(input logic [NT-1:0] up, input logic [NT-1:0] dn, input int n);
        for (int i = 0; i < n; i++) begin
            useful = up;
            wasted = dn;
            @(negedge clk);
        end
        useful = '0;
        wasted = '0;
    endtask

    task automatic expect_announce(input string req, input logic [NT-1:0] exp_en,
                                   input logic exp_resync);
        logic [NT-1:0] off;
        off = ~exp_en;
        at_phase(1);
        check({req, " enables"}, int'(en), int'(exp_en));
        check({req, " valid"}, int'(rv), int'(|off));
        check({req, " mask"}, int'(rmask), (|off) ? int'(off) : 0);
        check({req, " id"}, int'(rid), (|off) ? int'(pid) : 0);
        check({req, " resync"}, int'(resync), int'(exp_resync));
        @(negedge clk);
        check({req, " R7 strobe drops"}, int'(rv), 0);
        check({req, " R8 pulse drops"}, int'(resync), 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 enables in reset", int'(en), 7);
        check("R1 valid in reset", int'(rv), 0);
        check("R1 resync in reset", int'(resync), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enables after reset", int'(en), 7);
        expect_announce("R1 R4 idle window", 3'b111, 1'b0);
    endtask

    task automatic t_single_disable;
        at_phase(2);
        drive(3'b000, 3'b010, 1);
        at_phase(0);
        check("R6 enables hold in verdict", int'(en), 7);
        check("R5 no report in verdict", int'(rv), 0);
        expect_announce("R2 R5 R7 single wasted", 3'b101, 1'b0);
    endtask

    task automatic t_majority;
        at_phase(2);
        pid = 6'h15;
        drive(3'b000, 3'b101, 3);
        expect_announce("R8 two of three off", 3'b010, 1'b1);
    endtask

    task automatic t_all_off;
        at_phase(2);
        drive(3'b000, 3'b111, 20);
        expect_announce("R3 R8 all off deep", 3'b000, 1'b1);
    endtask

    task automatic t_recover;
        expect_announce("R4 recovery after reload", 3'b111, 1'b0);
    endtask

    task automatic t_saturate;
        at_phase(2);
        drive(3'b100, 3'b001, 10);
        drive(3'b001, 3'b100, 8);
        expect_announce("R3 saturation both rails", 3'b011, 1'b0);
    endtask

    task automatic t_cancel_tie;
        at_phase(2);
        drive(3'b011, 3'b011, 6);
        drive(3'b000, 3'b001, 1);
        drive(3'b100, 3'b000, 4);
        drive(3'b000, 3'b100, 4);
        expect_announce("R2 R9 cancel and tie", 3'b110, 1'b0);
    endtask

    task automatic t_verdict_drop;
        at_phase(0);
        drive(3'b000, 3'b010, 1);
        expect_announce("R4 previous window clean", 3'b111, 1'b0);
        expect_announce("R4 verdict pulse dropped", 3'b111, 1'b0);
    endtask

    initial begin
        t_reset;
        t_single_disable;
        t_majority;
        t_all_off;
        t_recover;
        t_saturate;
        t_cancel_tie;
        t_verdict_drop;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule